// File: doc/BRIEF.md
# UART Receiver with Per-Character Error Classification

This block turns an asynchronous serial input line into characters. The frame format is set by three small configuration inputs: 5 to 8 data bits, parity that is odd, even or absent, and a stop length of one, one and a half or two bits. Timing comes from an internal tick generator that pulses once every `divisor` clocks. Each bit spans sixteen ticks, and bits are sampled at their centre.

Every finished character goes into a single output holding slot along with three status flags: parity error, framing error and break. The consumer reads the slot and frees it with `rd_ack`. If a character completes while the slot is still occupied, the new character is dropped and `overflow` pulses for one cycle. A separate level output, `idle`, reports that the line has carried no start bit for four character times.

Top module: `uart_rx`

## Requirements
- R1: `word_len` selects the data bit count: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. The bits of `char_data` at or above the data bit count read as zero.
- R2: The first data bit after the start bit lands in `char_data[0]`, and each later bit takes the next higher position.
- R3: `parity_sel` selects the parity: 1 is odd, 2 is even, and 0 or 3 is none. With parity on, `char_perr` is set when the received data bits plus the parity bit hold the wrong total count of ones. With parity off, no parity bit is expected and `char_perr` is 0.
- R4: `stop_sel` selects the stop length: 0 is one bit, 1 is one and a half bits, and 2 or 3 is two bits. Only whole stop bits are sampled, so one or two samples are taken. `char_ferr` is set when any sampled stop bit is low.
- R5: When the line is low at every sample of a frame (start, data, parity and every sampled stop bit), exactly one character is delivered with `char_brk`=1, `char_ferr`=1, `char_perr`=0 and `char_data`=0. No further character is delivered until the line has gone high again.
- R6: A falling edge is accepted as a start bit only if the line is still low eight ticks later. A shorter low pulse produces no character.
- R7: `idle` rises after the line has waited for a start bit for four character times, where one character time is 16 ticks per start, data and parity bit plus 16, 24 or 32 ticks for the stop length. `idle` falls as soon as a low level is seen while waiting.
- R8: `char_valid` stays high from the delivery of a character until a cycle in which `rd_ack` is high. A character that completes while the slot is full and not being acknowledged is discarded, `overflow` pulses for one cycle, and the held character stays unchanged.
- R9: After synchronous reset, `char_valid`, `overflow` and `idle` are 0.
- R10: A tick is produced every `divisor` clocks, with 0 treated as 1. Reception works for any divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| divisor | input | DIV_W | Clocks per oversampling tick |
| word_len | input | 2 | Data bit count code |
| parity_sel | input | 2 | Parity mode code |
| stop_sel | input | 2 | Stop length code |
| rx_in | input | 1 | Serial input line (asynchronous) |
| rd_ack | input | 1 | Consumer frees the holding slot |
| char_valid | output | 1 | Holding slot contains a character |
| char_data | output | 8 | Received character, LSB first on the line |
| char_perr | output | 1 | Parity error for the held character |
| char_ferr | output | 1 | Framing error for the held character |
| char_brk | output | 1 | Held character is a break |
| overflow | output | 1 | One-cycle pulse: a character was dropped |
| idle | output | 1 | Line idle for four character times |

## Verification
Assertions check four things on every cycle. An overflow pulse leaves the held character unchanged. A held break character always reads zero, carries a framing error and carries no parity error. An acknowledge with no new arrival empties the slot. A confirmed start bit never coincides with `idle`. The bench scenarios cover the rest: correct bit order and width masking across all word lengths, parity and framing classification for each mode, rejection of a short glitch, a single delivery for a long break followed by recovery, the timing of the idle flag, and operation at a second divisor.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int OSR    = 16;
  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    ST_HUNT, ST_START, ST_DATA, ST_PAR, ST_STOP1, ST_STOP2, ST_BRKWAIT
  } rx_state_t;

  typedef struct packed {
    logic              brk;
    logic              ferr;
    logic              perr;
    logic [DATA_W-1:0] data;
  } rx_char_t;

  function automatic logic par_enabled(input logic [1:0] sel);
    return (sel == 2'd1) || (sel == 2'd2);
  endfunction
endpackage

// File: rtl/rx_baud_gen.sv
module rx_baud_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  // R10: divisor 0 behaves as 1
  assign lim = (divisor == '0) ? '0 : divisor - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= lim) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '1;
    else     pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/rx_frame.sv
module rx_frame
  import uart_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       rxs,
  input  logic [1:0] word_len,
  input  logic [1:0] parity_sel,
  input  logic [1:0] stop_sel,
  output logic       done,
  output rx_char_t   result,
  output logic       in_hunt,
  output logic       start_ok
);
  rx_state_t         state;
  logic [3:0]        tcnt;
  logic [2:0]        bidx;
  logic [DATA_W-1:0] shreg;
  logic              par_acc;
  logic              all_low;
  logic              ferr_acc;
  logic [2:0]        last_idx;
  logic              mid;
  logic              two_stops;
  logic              fin_brk;
  logic              perr_calc;

  assign last_idx  = {1'b0, word_len} + 3'd4;
  assign mid       = (tcnt == 4'd15);
  assign two_stops = stop_sel[1];
  assign fin_brk   = all_low & ~rxs;
  // R3: odd wants an odd total of ones, even wants an even total
  assign perr_calc = par_enabled(parity_sel) &
                     ((parity_sel == 2'd1) ? ~par_acc : par_acc);
  assign in_hunt   = (state == ST_HUNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_HUNT;
      tcnt     <= '0;
      bidx     <= '0;
      shreg    <= '0;
      par_acc  <= 1'b0;
      all_low  <= 1'b0;
      ferr_acc <= 1'b0;
      done     <= 1'b0;
      start_ok <= 1'b0;
      result   <= '0;
    end else begin
      done     <= 1'b0;
      start_ok <= 1'b0;
      if (tick) begin
        case (state)
          ST_HUNT: begin
            if (!rxs) begin
              state <= ST_START;
              tcnt  <= '0;
            end
          end
          ST_START: begin
            // R6: confirm the start bit at its centre
            if (tcnt == 4'd7) begin
              if (!rxs) begin
                state    <= ST_DATA;
                tcnt     <= '0;
                bidx     <= '0;
                shreg    <= '0;
                par_acc  <= 1'b0;
                all_low  <= 1'b1;
                ferr_acc <= 1'b0;
                start_ok <= 1'b1;
              end else begin
                state <= ST_HUNT;
              end
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          ST_DATA: begin
            tcnt <= tcnt + 1'b1;
            if (mid) begin
              // R2: LSB first
              shreg[bidx] <= rxs;
              par_acc     <= par_acc ^ rxs;
              all_low     <= all_low & ~rxs;
              // R1: stop after the programmed bit count
              if (bidx == last_idx)
                state <= par_enabled(parity_sel) ? ST_PAR : ST_STOP1;
              else
                bidx <= bidx + 1'b1;
            end
          end
          ST_PAR: begin
            tcnt <= tcnt + 1'b1;
            if (mid) begin
              par_acc <= par_acc ^ rxs;
              all_low <= all_low & ~rxs;
              state   <= ST_STOP1;
            end
          end
          ST_STOP1: begin
            tcnt <= tcnt + 1'b1;
            if (mid) begin
              if (two_stops) begin
                ferr_acc <= ~rxs;
                all_low  <= all_low & ~rxs;
                state    <= ST_STOP2;
              end else begin
                done        <= 1'b1;
                result.brk  <= fin_brk;
                result.ferr <= ~rxs;
                result.perr <= fin_brk ? 1'b0 : perr_calc;
                result.data <= fin_brk ? '0 : shreg;
                state       <= fin_brk ? ST_BRKWAIT : ST_HUNT;
              end
            end
          end
          ST_STOP2: begin
            tcnt <= tcnt + 1'b1;
            if (mid) begin
              // R4: either stop sample low is a framing error
              done        <= 1'b1;
              result.brk  <= fin_brk;
              result.ferr <= ferr_acc | ~rxs;
              result.perr <= fin_brk ? 1'b0 : perr_calc;
              result.data <= fin_brk ? '0 : shreg;
              state       <= fin_brk ? ST_BRKWAIT : ST_HUNT;
            end
          end
          ST_BRKWAIT: begin
            // R5: resume hunting only after the line goes high
            if (rxs) state <= ST_HUNT;
          end
          default: state <= ST_HUNT;
        endcase
      end
    end
  end
endmodule

// File: rtl/rx_idle.sv
module rx_idle #(
  parameter int IDLE_CHARS = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       in_hunt,
  input  logic       rxs,
  input  logic [1:0] word_len,
  input  logic [1:0] parity_sel,
  input  logic [1:0] stop_sel,
  output logic       idle
);
  import uart_rx_pkg::*;
  localparam int MAX_CT = OSR * 10 + 2 * OSR;
  localparam int IW     = $clog2(IDLE_CHARS * MAX_CT + 1);

  logic [IW-1:0] cnt;
  logic [IW-1:0] limit;
  int            ct;
  int            st;

  always_comb begin
    case (stop_sel)
      2'd0:    st = OSR;
      2'd1:    st = OSR + OSR / 2;
      default: st = 2 * OSR;
    endcase
    ct    = OSR * (6 + int'(word_len) + (par_enabled(parity_sel) ? 1 : 0)) + st;
    limit = IW'(IDLE_CHARS * ct);
  end

  // R7: count ticks spent waiting on a high line
  always_ff @(posedge clk) begin
    if (rst || !in_hunt || !rxs) begin
      cnt  <= '0;
      idle <= 1'b0;
    end else if (tick && !idle) begin
      if (cnt == limit - 1'b1) idle <= 1'b1;
      else                     cnt  <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rx_hold.sv
module rx_hold
  import uart_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     done,
  input  rx_char_t in_char,
  input  logic     rd_ack,
  output logic     valid,
  output rx_char_t out_char,
  output logic     overflow
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid    <= 1'b0;
      overflow <= 1'b0;
      out_char <= '0;
    end else begin
      overflow <= 1'b0;
      if (done) begin
        if (valid && !rd_ack) begin
          overflow <= 1'b1;
        end else begin
          out_char <= in_char;
          valid    <= 1'b1;
        end
      end else if (rd_ack) begin
        valid <= 1'b0;
      end
    end
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |-> (valid && $stable(out_char)));

  // R8
  ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && rd_ack && !done) |=> !valid);

  // R5
  break_char_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && out_char.brk) |-> (out_char.data == '0 && out_char.ferr && !out_char.perr));
endmodule

// File: rtl/uart_rx.sv
module uart_rx
  import uart_rx_pkg::*;
#(
  parameter int DIV_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int IDLE_CHARS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] divisor,
  input  logic [1:0]       word_len,
  input  logic [1:0]       parity_sel,
  input  logic [1:0]       stop_sel,
  input  logic             rx_in,
  input  logic             rd_ack,
  output logic             char_valid,
  output logic [7:0]       char_data,
  output logic             char_perr,
  output logic             char_ferr,
  output logic             char_brk,
  output logic             overflow,
  output logic             idle
);
  logic     tick;
  logic     rxs;
  logic     done;
  logic     in_hunt;
  logic     start_ok;
  rx_char_t fr_char;
  rx_char_t held;

  rx_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst(rst), .divisor(divisor), .tick(tick)
  );

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(rx_in), .q(rxs)
  );

  rx_frame u_frame (
    .clk(clk), .rst(rst), .tick(tick), .rxs(rxs),
    .word_len(word_len), .parity_sel(parity_sel), .stop_sel(stop_sel),
    .done(done), .result(fr_char), .in_hunt(in_hunt), .start_ok(start_ok)
  );

  rx_idle #(.IDLE_CHARS(IDLE_CHARS)) u_idle (
    .clk(clk), .rst(rst), .tick(tick), .in_hunt(in_hunt), .rxs(rxs),
    .word_len(word_len), .parity_sel(parity_sel), .stop_sel(stop_sel),
    .idle(idle)
  );

  rx_hold u_hold (
    .clk(clk), .rst(rst), .done(done), .in_char(fr_char), .rd_ack(rd_ack),
    .valid(char_valid), .out_char(held), .overflow(overflow)
  );

  assign char_data = held.data;
  assign char_perr = held.perr;
  assign char_ferr = held.ferr;
  assign char_brk  = held.brk;

  // R7
  idle_start_chk: assert property (@(posedge clk) disable iff (rst)
    start_ok |-> !idle);
endmodule

// File: tb/tb_uart_rx.sv
module tb_uart_rx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] divisor = 16'd2;
  logic [1:0]  word_len = 2'd3;
  logic [1:0]  parity_sel = 2'd0;
  logic [1:0]  stop_sel = 2'd0;
  logic        rx_in = 1'b1;
  logic        rd_ack = 1'b0;
  logic        char_valid, char_perr, char_ferr, char_brk, overflow, idle;
  logic [7:0]  char_data;

  int checks = 0;
  int fails = 0;
  int ovf_cnt = 0;
  int bitc = 32;
  bit stall = 1'b0;
  bit finished = 1'b0;
  logic [10:0] exp_q[$];
  string       req_q[$];

  always #2 clk = ~clk;

  uart_rx dut (
    .clk(clk), .rst(rst), .divisor(divisor), .word_len(word_len),
    .parity_sel(parity_sel), .stop_sel(stop_sel), .rx_in(rx_in),
    .rd_ack(rd_ack), .char_valid(char_valid), .char_data(char_data),
    .char_perr(char_perr), .char_ferr(char_ferr), .char_brk(char_brk),
    .overflow(overflow), .idle(idle)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (overflow) ovf_cnt++;
    if (rd_ack) rd_ack = 1'b0;
    else if (char_valid && !stall) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6/R5 unexpected character", {char_brk, char_ferr, char_perr, char_data}, 0);
      end else begin
        logic [10:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        chk({char_brk, char_ferr, char_perr, char_data} == e, r,
            {char_brk, char_ferr, char_perr, char_data}, e);
      end
      rd_ack = 1'b1;
    end
  end

  task automatic hold_bit(input logic v, input int n);
    rx_in = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit flip_par, input bit s1_low,
                      input bit s2_low, input bit push, input string req);
    int   nb;
    logic [7:0] mask;
    logic p;
    bit   pen;
    nb   = int'(word_len) + 5;
    mask = 8'hFF >> (8 - nb);
    pen  = (parity_sel == 2'd1) || (parity_sel == 2'd2);
    p    = ^(d & mask);
    if (parity_sel == 2'd1) p = ~p;
    if (flip_par) p = ~p;
    if (push) begin
      exp_q.push_back({1'b0, s1_low | (stop_sel[1] & s2_low), pen & flip_par, d & mask});
      req_q.push_back(req);
    end
    hold_bit(1'b0, bitc);
    for (int i = 0; i < nb; i++) hold_bit(d[i], bitc);
    if (pen) hold_bit(p, bitc);
    hold_bit(~s1_low, bitc);
    if (stop_sel == 2'd1) hold_bit(1'b1, bitc / 2);
    if (stop_sel[1]) hold_bit(~s2_low, bitc);
    hold_bit(1'b1, 2 * bitc);
  endtask

  task automatic drain();
    int w = 0;
    while ((exp_q.size() != 0 || char_valid) && w < 2000) begin
      @(negedge clk);
      w++;
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9
    chk(char_valid == 1'b0, "R9 valid after reset", char_valid, 0);
    chk(overflow == 1'b0, "R9 overflow after reset", overflow, 0);
    chk(idle == 1'b0, "R9 idle after reset", idle, 0);

    // 8N1, R1 R2
    send(8'hA5, 0, 0, 0, 1, "R2 8N1 A5");
    send(8'h3C, 0, 0, 0, 1, "R2 8N1 3C");
    drain();
    // R7: idle timing (640 ticks = 1280 clocks at divisor 2)
    repeat (1000) @(negedge clk);
    chk(idle == 1'b0, "R7 idle too early", idle, 0);
    repeat (400) @(negedge clk);
    chk(idle == 1'b1, "R7 idle after four char times", idle, 1);
    send(8'h81, 0, 0, 0, 1, "R2 8N1 81");
    chk(idle == 1'b0, "R7 idle cleared by start", idle, 0);
    drain();

    // 7E1 with good and bad parity, R3
    word_len = 2'd2; parity_sel = 2'd2;
    send(8'hD5, 0, 0, 0, 1, "R1 7E1 masked");
    send(8'h37, 1, 0, 0, 1, "R3 even parity error");
    drain();
    // 5O1
    word_len = 2'd0; parity_sel = 2'd1;
    send(8'hFF, 0, 0, 0, 1, "R1 5O1 masked");
    send(8'h0A, 1, 0, 0, 1, "R3 odd parity error");
    drain();
    // 6 bits no parity (code 3), 2 stops
    word_len = 2'd1; parity_sel = 2'd3; stop_sel = 2'd2;
    send(8'h2D, 0, 0, 0, 1, "R3 no parity 2 stops");
    send(8'h15, 0, 0, 1, 1, "R4 second stop low");
    send(8'h21, 0, 1, 0, 1, "R4 first stop low");
    drain();
    // 1.5 stop, framing on first stop
    word_len = 2'd3; parity_sel = 2'd0; stop_sel = 2'd1;
    send(8'h5A, 0, 0, 0, 1, "R4 1.5 stops ok");
    send(8'h6E, 0, 1, 0, 1, "R4 1.5 stops framing");
    drain();

    // R5 break: long low, one zero char, then recovery
    stop_sel = 2'd0;
    exp_q.push_back(11'b110_0000_0000);
    req_q.push_back("R5 break char");
    hold_bit(1'b0, 14 * bitc);
    drain();
    hold_bit(1'b0, 30 * bitc);
    chk(char_valid == 1'b0 && exp_q.size() == 0, "R5 single break char", char_valid, 0);
    hold_bit(1'b1, 2 * bitc);
    send(8'hC3, 0, 0, 0, 1, "R5 recovery after break");
    drain();

    // R6 glitch shorter than half a bit
    hold_bit(1'b0, 8);
    hold_bit(1'b1, 3 * bitc);
    chk(char_valid == 1'b0, "R6 glitch ignored", char_valid, 0);
    send(8'h99, 0, 0, 0, 1, "R6 frame after glitch");
    drain();

    // R8 overflow: slot full, second char dropped
    stall = 1'b1;
    ovf_cnt = 0;
    send(8'h11, 0, 0, 0, 1, "R8 held char kept");
    send(8'h22, 0, 0, 0, 0, "R8 dropped");
    chk(ovf_cnt == 1, "R8 overflow pulse count", ovf_cnt, 1);
    chk(char_valid == 1'b1, "R8 slot still full", char_valid, 1);
    stall = 1'b0;
    drain();
    repeat (4) @(negedge clk);
    chk(char_valid == 1'b0 && exp_q.size() == 0, "R8 second char discarded", char_valid, 0);

    // R10 different divisor (and 0 treated as 1)
    divisor = 16'd5; bitc = 80;
    send(8'h4B, 0, 0, 0, 1, "R10 divisor 5");
    drain();
    divisor = 16'd0; bitc = 16;
    send(8'hE7, 0, 0, 0, 1, "R10 divisor 0");
    drain();
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R8 all chars delivered", exp_q.size(), 0);
    summary();
  end
endmodule